// File: doc/BRIEF.md
# Programmed I/O Strobe Sequencer

This block times the control side of programmed I/O cycles on a parallel disk bus with two channels, each carrying two devices. Each device has its own timing byte, which holds an active-pulse count and a recovery count. A shared byte holds a short address-setup count for every device. When a cycle request names a device and a direction, the block asserts the channel chip select and device select. It then waits out the setup time, drives the read or write strobe for the active time and releases it for the recovery time. Done is flagged in the last recovery clock.

The timing values for a cycle are captured when the request is accepted. One sequencer therefore retimes itself for each access, and software may reprogram a device while a cycle to it is in flight. A device that is not ready holds its ready line low, and this stretches the strobe clock by clock. All counts are stored as the clock count minus one.

Top module: `pio_strobe_timer`

## Requirements
- R1: After reset every timing byte reads 0xA8 (11 active, 9 recovery clocks) and every setup field reads 3 (4 clocks). The block is idle with `cmd_ready` high and `addr_valid`, both strobes and `done` low.
- R2: The timing word is packed with drive 0 in bits [31:24], drive 1 in [23:16], drive 2 in [15:8] and drive 3 in [7:0]. The drive number is {channel, device}.
- R3: In a timing byte the upper nibble is the active clock count minus one and the lower nibble is the recovery clock count minus one.
- R4: The setup word gives drive 0 bits [7:6], drive 1 [5:4], drive 2 [3:2] and drive 3 [1:0]. The setup time is the field value plus one clocks.
- R5: After acceptance, `addr_valid` is high for setup+active+recovery clocks in a row. The strobe is high only in the active window, and `done` is high only in the final recovery clock.
- R6: A write request (`cmd_write`=1) pulses only `wr_strobe` and a read pulses only `rd_strobe`. The two strobes are never high together.
- R7: During a cycle, `cs_chan` is one-hot with bit (drive>>1) set and `dev_sel` equals drive bit 0. Both hold steady for the whole cycle.
- R8: Each clock edge in the active phase at which `iordy` is low adds one clock to the active phase.
- R9: A request is accepted only when idle. `cmd_ready` is low from acceptance through `done`. A request held pending during a cycle starts after at least one idle clock.
- R10: A timing or setup write made while a cycle runs does not alter that cycle. It applies to the next accepted request.
- R11: A low `iordy` during the setup or recovery phase does not change their length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tim_we | input | 1 | Load the packed timing word |
| tim_wdata | input | 32 | Packed per-drive timing bytes |
| setup_we | input | 1 | Load the packed setup word |
| setup_wdata | input | 8 | Packed per-drive setup fields |
| cmd_valid | input | 1 | Cycle request |
| cmd_drive | input | 2 | Target drive {channel, device} |
| cmd_write | input | 1 | 1 = write cycle, 0 = read cycle |
| cmd_ready | output | 1 | Sequencer idle, request taken this clock |
| iordy | input | 1 | Device ready; low stretches the active phase |
| addr_valid | output | 1 | Address and selects valid for the cycle |
| cs_chan | output | 2 | One-hot channel chip select |
| dev_sel | output | 1 | Device select within the channel |
| rd_strobe | output | 1 | Read strobe, active high |
| wr_strobe | output | 1 | Write strobe, active high |
| done | output | 1 | Final clock of the cycle |

## Verification
The first pattern is a read issued on reset values, which separates the reset defaults from programmed values. The bench then programs four distinct timing bytes and four distinct setup fields and runs a cycle to each drive with reads and writes mixed. This exposes any byte or field taken from the wrong slot, any swap of the two nibbles and any strobe on the wrong line. Ready-low pulses placed in the setup, active and recovery phases check that only the active phase stretches. A reprogram in mid-cycle and a request held pending across a busy cycle check the point at which values are captured and that the cycles do not overlap.

// File: rtl/pio_tmr_pkg.sv
package pio_tmr_pkg;

   typedef enum logic [1:0] {
      PH_IDLE   = 2'd0,
      PH_SETUP  = 2'd1,
      PH_ACTIVE = 2'd2,
      PH_RECOV  = 2'd3
   } phase_e;

   localparam logic [7:0] SLOW_TIMING_BYTE = 8'hA8;
   localparam logic [1:0] SLOW_SETUP_FIELD = 2'b11;

endpackage

// File: rtl/pio_timing_regs.sv
module pio_timing_regs #(
   parameter int          TWORD_W   = 32,
   parameter int          SWORD_W   = 8,
   parameter int          N_DRV     = 4,
   parameter logic [7:0]  RST_TBYTE = 8'hA8,
   parameter logic [1:0]  RST_SFLD  = 2'b11
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               tim_we,
   input  logic [TWORD_W-1:0] tim_wdata,
   input  logic               setup_we,
   input  logic [SWORD_W-1:0] setup_wdata,
   output logic [TWORD_W-1:0] tim_q,
   output logic [SWORD_W-1:0] setup_q
);
   localparam int TBYTE_W = TWORD_W / N_DRV;
   localparam int SFLD_W  = SWORD_W / N_DRV;

   logic [TWORD_W-1:0] tim_rst;
   logic [SWORD_W-1:0] setup_rst;

   for (genvar d = 0; d < N_DRV; d++) begin : g_rst
      assign tim_rst[d*TBYTE_W +: TBYTE_W]  = TBYTE_W'(RST_TBYTE);
      assign setup_rst[d*SFLD_W +: SFLD_W]  = SFLD_W'(RST_SFLD);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tim_q   <= tim_rst;
         setup_q <= setup_rst;
      end else begin
         if (tim_we)   tim_q   <= tim_wdata;
         if (setup_we) setup_q <= setup_wdata;
      end
   end

   AST_TIM_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      !tim_we |=> $stable(tim_q)) else $error("timing word moved"); // R2
   AST_SETUP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      !setup_we |=> $stable(setup_q)) else $error("setup word moved"); // R4

endmodule

// File: rtl/pio_drive_slice.sv
module pio_drive_slice #(
   parameter int N_DRV   = 4,
   parameter int NIB_W   = 4,
   parameter int SETUP_W = 2,
   parameter int DRV_W   = 2
) (
   input  logic [N_DRV*2*NIB_W-1:0] tim_word,
   input  logic [N_DRV*SETUP_W-1:0] setup_word,
   input  logic [DRV_W-1:0]         drive,
   output logic [NIB_W-1:0]         act_m1,
   output logic [NIB_W-1:0]         rec_m1,
   output logic [SETUP_W-1:0]       setup_m1
);
   localparam int TBYTE_W = 2 * NIB_W;
   localparam int TWORD_W = N_DRV * TBYTE_W;
   localparam int SWORD_W = N_DRV * SETUP_W;

   logic [NIB_W-1:0]   act_a [N_DRV];
   logic [NIB_W-1:0]   rec_a [N_DRV];
   logic [SETUP_W-1:0] set_a [N_DRV];

   // drive 0 owns the most significant slot of each packed word
   for (genvar d = 0; d < N_DRV; d++) begin : g_unpack
      assign act_a[d] = tim_word[TWORD_W-1-d*TBYTE_W -: NIB_W];
      assign rec_a[d] = tim_word[TWORD_W-1-d*TBYTE_W-NIB_W -: NIB_W];
      assign set_a[d] = setup_word[SWORD_W-1-d*SETUP_W -: SETUP_W];
   end

   assign act_m1   = act_a[drive];
   assign rec_m1   = rec_a[drive];
   assign setup_m1 = set_a[drive];

endmodule

// File: rtl/pio_phase_seq.sv
module pio_phase_seq
   import pio_tmr_pkg::*;
#(
   parameter int NIB_W   = 4,
   parameter int SETUP_W = 2,
   parameter int DRV_W   = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cmd_valid,
   input  logic [DRV_W-1:0]   cmd_drive,
   input  logic               cmd_write,
   input  logic [NIB_W-1:0]   sel_act,
   input  logic [NIB_W-1:0]   sel_rec,
   input  logic [SETUP_W-1:0] sel_setup,
   input  logic               iordy,
   output logic               cmd_ready,
   output logic               busy,
   output logic               strobe_rd,
   output logic               strobe_wr,
   output logic               last,
   output logic [DRV_W-1:0]   drv_q
);
   localparam int CNT_W = (NIB_W > SETUP_W) ? NIB_W : SETUP_W;

   phase_e           st;
   logic [CNT_W-1:0] cnt;
   logic [NIB_W-1:0] act_q, rec_q;
   logic             wr_q;
   logic             cnt_zero;

   assign cnt_zero = (cnt == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st    <= PH_IDLE;
         cnt   <= '0;
         act_q <= '0;
         rec_q <= '0;
         wr_q  <= 1'b0;
         drv_q <= '0;
      end else begin
         unique case (st)
            PH_IDLE: if (cmd_valid) begin
               drv_q <= cmd_drive;
               wr_q  <= cmd_write;
               act_q <= sel_act;
               rec_q <= sel_rec;
               cnt   <= CNT_W'(sel_setup);
               st    <= PH_SETUP;
            end
            PH_SETUP: if (cnt_zero) begin
               cnt <= CNT_W'(act_q);
               st  <= PH_ACTIVE;
            end else begin
               cnt <= cnt - CNT_W'(1);
            end
            PH_ACTIVE: if (iordy) begin
               if (cnt_zero) begin
                  cnt <= CNT_W'(rec_q);
                  st  <= PH_RECOV;
               end else begin
                  cnt <= cnt - CNT_W'(1);
               end
            end
            PH_RECOV: if (cnt_zero) begin
               st <= PH_IDLE;
            end else begin
               cnt <= cnt - CNT_W'(1);
            end
            default: st <= PH_IDLE;
         endcase
      end
   end

   assign cmd_ready = (st == PH_IDLE);
   assign busy      = (st != PH_IDLE);
   assign strobe_rd = (st == PH_ACTIVE) && !wr_q;
   assign strobe_wr = (st == PH_ACTIVE) &&  wr_q;
   assign last      = (st == PH_RECOV) && cnt_zero;

   AST_IORDY_STRETCH: assert property (@(posedge clk) disable iff (!rst_n)
      (st == PH_ACTIVE && !iordy) |=> (st == PH_ACTIVE && $stable(cnt)))
      else $error("active phase not held"); // R8
   AST_SETUP_IGNORES_IORDY: assert property (@(posedge clk) disable iff (!rst_n)
      (st == PH_SETUP && !cnt_zero) |=> (cnt == $past(cnt) - CNT_W'(1)))
      else $error("setup count disturbed"); // R11
   AST_RECOV_IGNORES_IORDY: assert property (@(posedge clk) disable iff (!rst_n)
      (st == PH_RECOV && !cnt_zero) |=> (st == PH_RECOV))
      else $error("recovery cut short"); // R11
   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      last |=> !last) else $error("done longer than one clock"); // R5
   AST_CAPTURE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (st != PH_IDLE) |=> ($stable(drv_q) && $stable(wr_q) && $stable(act_q)))
      else $error("captured request changed mid-cycle"); // R10

endmodule

// File: rtl/pio_strobe_timer.sv
module pio_strobe_timer
   import pio_tmr_pkg::*;
#(
   parameter int N_CHAN       = 2,
   parameter int DEV_PER_CHAN = 2,
   parameter int NIB_W        = 4,
   parameter int SETUP_W      = 2,
   localparam int N_DRV       = N_CHAN * DEV_PER_CHAN,
   localparam int DRV_W       = $clog2(N_DRV),
   localparam int DEV_BITS    = $clog2(DEV_PER_CHAN),
   localparam int DEV_W       = (DEV_BITS > 0) ? DEV_BITS : 1,
   localparam int TWORD_W     = N_DRV * 2 * NIB_W,
   localparam int SWORD_W     = N_DRV * SETUP_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               tim_we,
   input  logic [TWORD_W-1:0] tim_wdata,
   input  logic               setup_we,
   input  logic [SWORD_W-1:0] setup_wdata,
   input  logic               cmd_valid,
   input  logic [DRV_W-1:0]   cmd_drive,
   input  logic               cmd_write,
   output logic               cmd_ready,
   input  logic               iordy,
   output logic               addr_valid,
   output logic [N_CHAN-1:0]  cs_chan,
   output logic [DEV_W-1:0]   dev_sel,
   output logic               rd_strobe,
   output logic               wr_strobe,
   output logic               done
);
   // elaboration-time parameter checks
   if (N_DRV < 2 || (1 << DRV_W) != N_DRV) begin : g_bad_drv
      $error("drive count must be a power of two, at least 2");
   end
   if ((1 << DEV_BITS) != DEV_PER_CHAN) begin : g_bad_dev
      $error("devices per channel must be a power of two");
   end
   if (NIB_W < 1 || SETUP_W < 1) begin : g_bad_w
      $error("count fields need at least one bit");
   end

   logic [TWORD_W-1:0] tim_q;
   logic [SWORD_W-1:0] setup_q;
   logic [NIB_W-1:0]   sel_act, sel_rec;
   logic [SETUP_W-1:0] sel_setup;
   logic [DRV_W-1:0]   drv_q;
   logic [DRV_W-1:0]   chan_idx;
   logic               busy;

   pio_timing_regs #(
      .TWORD_W   (TWORD_W),
      .SWORD_W   (SWORD_W),
      .N_DRV     (N_DRV),
      .RST_TBYTE (SLOW_TIMING_BYTE),
      .RST_SFLD  (SLOW_SETUP_FIELD)
   ) u_regs (
      .clk         (clk),
      .rst_n       (rst_n),
      .tim_we      (tim_we),
      .tim_wdata   (tim_wdata),
      .setup_we    (setup_we),
      .setup_wdata (setup_wdata),
      .tim_q       (tim_q),
      .setup_q     (setup_q)
   );

   pio_drive_slice #(
      .N_DRV   (N_DRV),
      .NIB_W   (NIB_W),
      .SETUP_W (SETUP_W),
      .DRV_W   (DRV_W)
   ) u_slice (
      .tim_word   (tim_q),
      .setup_word (setup_q),
      .drive      (cmd_drive),
      .act_m1     (sel_act),
      .rec_m1     (sel_rec),
      .setup_m1   (sel_setup)
   );

   pio_phase_seq #(
      .NIB_W   (NIB_W),
      .SETUP_W (SETUP_W),
      .DRV_W   (DRV_W)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_valid (cmd_valid),
      .cmd_drive (cmd_drive),
      .cmd_write (cmd_write),
      .sel_act   (sel_act),
      .sel_rec   (sel_rec),
      .sel_setup (sel_setup),
      .iordy     (iordy),
      .cmd_ready (cmd_ready),
      .busy      (busy),
      .strobe_rd (rd_strobe),
      .strobe_wr (wr_strobe),
      .last      (done),
      .drv_q     (drv_q)
   );

   assign addr_valid = busy;

   if (DEV_BITS == 0) begin : g_one_dev
      assign chan_idx = drv_q;
      assign dev_sel  = '0;
   end else begin : g_multi_dev
      assign chan_idx = drv_q >> DEV_BITS;
      assign dev_sel  = busy ? drv_q[DEV_W-1:0] : '0;
   end

   for (genvar c = 0; c < N_CHAN; c++) begin : g_cs
      assign cs_chan[c] = busy && (chan_idx == DRV_W'(c));
   end

   AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      !(rd_strobe && wr_strobe)) else $error("both strobes high"); // R6
   AST_STROBE_IN_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_strobe || wr_strobe || done) |-> addr_valid)
      else $error("strobe outside cycle"); // R5
   AST_READY_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_ready |-> !addr_valid) else $error("ready while busy"); // R9
   AST_SEL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (addr_valid && $past(addr_valid)) |-> ($stable(cs_chan) && $stable(dev_sel)))
      else $error("select moved in cycle"); // R7
   AST_CS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      addr_valid |-> $onehot0(cs_chan) && (cs_chan != '0))
      else $error("chip select not one-hot"); // R7

endmodule

// File: tb/sim_pio_strobe_timer.sv
module sim_pio_strobe_timer;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 100000;

   typedef struct {
      int    s;
      int    a;
      int    r;
      bit    wr;
      int    drv;
      string tag;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tim_we = 1'b0;
   logic [31:0] tim_wdata = '0;
   logic        setup_we = 1'b0;
   logic [7:0]  setup_wdata = '0;
   logic        cmd_valid = 1'b0;
   logic [1:0]  cmd_drive = '0;
   logic        cmd_write = 1'b0;
   logic        cmd_ready;
   logic        iordy = 1'b1;
   logic        addr_valid;
   logic [1:0]  cs_chan;
   logic [0:0]  dev_sel;
   logic        rd_strobe, wr_strobe, done;

   int checks = 0;
   int errors = 0;
   exp_t q[$];
   logic [31:0] tim_m = 32'hA8A8A8A8;
   logic [7:0]  set_m = 8'hFF;

   pio_strobe_timer u0 (
      .clk(clk), .rst_n(rst_n),
      .tim_we(tim_we), .tim_wdata(tim_wdata),
      .setup_we(setup_we), .setup_wdata(setup_wdata),
      .cmd_valid(cmd_valid), .cmd_drive(cmd_drive), .cmd_write(cmd_write),
      .cmd_ready(cmd_ready), .iordy(iordy),
      .addr_valid(addr_valid), .cs_chan(cs_chan), .dev_sel(dev_sel),
      .rd_strobe(rd_strobe), .wr_strobe(wr_strobe), .done(done)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic chk(input int got, input int exp, input string what);
      checks++;
      if (got != exp) begin
         errors++;
         $display("FAIL %s: got %0d expected %0d", what, got, exp);
      end
   endtask

   task automatic finish_run();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   // driver: request a cycle; expected item captured at the acceptance clock
   task automatic issue(input int drv, input bit wr, input int stretch, input string tag);
      exp_t e;
      logic [7:0] tb;
      @(negedge clk);
      cmd_valid = 1'b1;
      cmd_drive = 2'(drv);
      cmd_write = wr;
      while (!cmd_ready) @(negedge clk);
      tb    = tim_m[31-8*drv -: 8];
      e.a   = int'(tb[7:4]) + 1 + stretch;
      e.r   = int'(tb[3:0]) + 1;
      e.s   = int'(set_m[7-2*drv -: 2]) + 1;
      e.wr  = wr;
      e.drv = drv;
      e.tag = tag;
      q.push_back(e);
      @(negedge clk);
      cmd_valid = 1'b0;
   endtask

   task automatic write_timing(input logic [31:0] v);
      tim_we = 1'b1; tim_wdata = v; tim_m = v;
      @(negedge clk);
      tim_we = 1'b0;
   endtask

   task automatic write_setup(input logic [7:0] v);
      setup_we = 1'b1; setup_wdata = v; set_m = v;
      @(negedge clk);
      setup_we = 1'b0;
   endtask

   task automatic ready_low(input int n);
      iordy = 1'b0;
      repeat (n) @(negedge clk);
      iordy = 1'b1;
   endtask

   task automatic wait_strobe_on();
      while (!(rd_strobe || wr_strobe)) @(negedge clk);
   endtask

   task automatic wait_strobe_off();
      wait_strobe_on();
      while (rd_strobe || wr_strobe) @(negedge clk);
   endtask

   task automatic drain();
      while (q.size() != 0 || addr_valid) @(negedge clk);
      @(negedge clk);
   endtask

   // monitor: measure each cycle and compare against the scoreboard
   bit in_cyc = 0, gap_chk = 0, saw_rd = 0, saw_wr = 0, sel_moved = 0;
   int s_n = 0, a_n = 0, r_n = 0;
   logic [1:0] cs0;
   logic [0:0] dv0;

   always @(negedge clk) begin
      if (rst_n) begin
         if (gap_chk) begin
            // R9: idle clock after done, next request not yet started
            chk(int'(addr_valid), 0, "R9 idle clock after done");
            gap_chk = 0;
         end
         if (done && !addr_valid) chk(0, 1, "R5 done outside cycle");
         if (addr_valid) begin
            if (!in_cyc) begin
               in_cyc = 1; s_n = 0; a_n = 0; r_n = 0;
               saw_rd = 0; saw_wr = 0; sel_moved = 0;
               cs0 = cs_chan; dv0 = dev_sel;
            end
            if (cs_chan != cs0 || dev_sel != dv0) sel_moved = 1;
            if (rd_strobe || wr_strobe) begin
               if (r_n != 0) chk(0, 1, "R5 strobe after recovery began");
               a_n++;
               saw_rd |= rd_strobe;
               saw_wr |= wr_strobe;
            end else if (a_n == 0) s_n++;
            else r_n++;
            if (done) begin
               in_cyc  = 0;
               gap_chk = 1;
               chk(int'(cmd_ready), 0, "R9 ready low during cycle");
               if (q.size() == 0) chk(0, 1, "R5 unexpected cycle");
               else begin
                  exp_t e;
                  e = q.pop_front();
                  $display("cycle %s drive %0d", e.tag, e.drv);
                  chk(s_n, e.s, {e.tag, " R4 setup clocks"});
                  chk(a_n, e.a, {e.tag, " R3/R8 active clocks"});
                  chk(r_n, e.r, {e.tag, " R3 recovery clocks"});
                  chk(int'(saw_wr), int'(e.wr), {e.tag, " R6 write strobe"});
                  chk(int'(saw_rd), int'(!e.wr), {e.tag, " R6 read strobe"});
                  chk(int'(cs0), 1 << (e.drv >> 1), {e.tag, " R7 channel select"});
                  chk(int'(dv0), e.drv & 1, {e.tag, " R7 device select"});
                  chk(int'(sel_moved), 0, {e.tag, " R7 select steady"});
               end
            end
         end
      end
   end

   initial begin
      for (int i = 0; i < WATCHDOG; i++) @(posedge clk);
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state at the ports
      chk(int'(cmd_ready), 1, "R1 ready in reset");
      chk(int'(addr_valid), 0, "R1 addr_valid in reset");
      chk(int'(rd_strobe | wr_strobe | done), 0, "R1 strobes in reset");
      rst_n = 1'b1;
      @(negedge clk);
      chk(int'(cmd_ready), 1, "R1 ready after reset");

      // R1: reset timing values in use (4 setup, 11 active, 9 recovery)
      issue(0, 1'b0, 0, "R1 defaults");
      drain();

      // R2 R3 R4: distinct bytes and fields per drive
      write_timing(32'h203165DB);
      write_setup(8'h1B);
      issue(0, 1'b1, 0, "R2 drive0 wr");
      issue(1, 1'b0, 0, "R2 drive1 rd");
      issue(2, 1'b1, 0, "R2 drive2 wr");
      issue(3, 1'b0, 0, "R2 drive3 rd");
      drain();

      // R8: ready low for 3 clocks in the active phase
      issue(2, 1'b0, 3, "R8 stretch");
      wait_strobe_on();
      ready_low(3);
      drain();

      // R11: ready low in setup, then in recovery, changes nothing
      issue(3, 1'b1, 0, "R11 setup");
      ready_low(2);
      drain();
      issue(3, 1'b0, 0, "R11 recovery");
      wait_strobe_off();
      ready_low(4);
      drain();

      // R10: reprogram drive 1 while its cycle runs
      issue(1, 1'b1, 0, "R10 old values");
      write_timing(32'h2010655B);
      write_setup(8'h0B);
      issue(1, 1'b1, 0, "R10 new values");
      drain();

      // R9: request held pending across a busy cycle
      issue(0, 1'b0, 0, "R9 first");
      issue(0, 1'b1, 0, "R9 pending");
      drain();

      finish_run();
   end

endmodule